// File: doc/BRIEF.md
# Shared-Pipeline Stereo Oscillator Bank

This block produces one stereo audio sample per sample period by summing many sine oscillators. Only one pipeline exists. All channels pass through it in turn, one per clock. Each channel's phase and phase step live in on-chip RAM, and so do its two gains. A lead channel counter walks the channels at the head of the pipeline. There the phase is advanced and written back, and its top bits select a sine amplitude. A trailing counter follows a fixed number of cycles behind. It fetches the same channel's left and right gains just as the delayed amplitude reaches the multiply-accumulate stage.

A free-running period counter starts one frame per sample period. The rest of the period is idle. When the last channel has been accumulated, both sums are scaled and clamped into the 16-bit sample registers. A one-cycle strobe marks the new pair, and both accumulators restart from zero. A host write port loads the phase steps and the gains. After reset, an initialisation sweep zeroes every RAM entry.

Sequencing is a four-state machine. INIT sweeps the RAMs. IDLE waits for the period tick. RUN issues channels through the lead counter. DRAIN waits for the pipeline to empty. Its transitions are: init_done (INIT to IDLE, after the last entry is cleared), frame_go (IDLE to RUN, on the tick), last_issued (RUN to DRAIN, after the last channel is issued) and last_summed (DRAIN to IDLE, when the last channel is accumulated and the sample is latched).

Top module: `osc_bank`

## Requirements
- R1: While reset is held, smp_valid, smp_left and smp_right are all zero. After reset is released, the block spends NCH cycles in INIT, clearing every phase, phase step and gain to zero. Host writes issued during INIT are discarded.
- R2: A frame starts once every FRAME_PERIOD cycles. smp_valid pulses exactly FRAME_PERIOD cycles apart, and each pulse is one cycle wide.
- R3: Each frame, every channel's 32-bit phase is advanced by its 32-bit step, modulo 2^32, and stored for the next frame. All phases start at zero.
- R4: A channel's amplitude is round-half-away-from-zero of 127*sin(2*pi*k/256), as a signed 8-bit value. Here k is bits [31:24] of the phase after that frame's advance.
- R5: The left sum is the sum over all channels of amplitude times signed 16-bit left gain, and the right sum likewise uses the right gain. Both sums use an accumulator of AMPW+GW+log2(NCH) bits, so they cannot overflow.
- R6: Each output sample is the accumulator arithmetically shifted right by OUT_SHIFT and clamped to the range -32768..32767.
- R7: Both accumulators are zero at the strobe and during IDLE. Each sample therefore reflects only its own frame.
- R8: The trailing counter that addresses the gain RAMs equals the channel the lead counter issued exactly LAT cycles earlier.
- R9: The host select field chooses the target: 0 writes the phase step (all 32 data bits), 1 writes the left gain (data bits [15:0]), 2 writes the right gain (data bits [15:0]), and 3 has no effect. A write takes effect at the addressed channel's next visit.
- R10: The states follow INIT, IDLE, RUN, DRAIN with the transitions init_done, frame_go, last_issued and last_summed. One channel is issued per clock, so the first strobe is visible 2*NCH+LAT+2 cycles after the first clock edge with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write enable |
| host_ch | input | log2(NCH) | Channel written by the host |
| host_sel | input | 2 | Write target: 0 step, 1 left gain, 2 right gain, 3 none |
| host_data | input | PHW | Write data (gains use the low GW bits) |
| smp_valid | output | 1 | One-cycle strobe when a new sample pair is latched |
| smp_left | output | OUTW | Left output sample, signed |
| smp_right | output | OUTW | Right output sample, signed |

## Verification
The assertions assume that FRAME_PERIOD leaves idle cycles after the pipeline drains, so no tick is lost while a frame is still in flight. They also assume that the lag LAT is at least 3. The bench uses eight channels with a 64-cycle period. It makes every host write in the idle window right after a strobe, so each write lands cleanly before the next frame reads it. Its reference model advances all phases frame by frame. It recomputes the amplitudes, sums and clamping arithmetically, and covers zero, mixed-sign and full-scale gains as well as writes made during INIT and writes with the no-effect select code.

// File: rtl/oscb_pkg.sv
package oscb_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        SEL_STEP   = 2'd0,
        SEL_GAIN_L = 2'd1,
        SEL_GAIN_R = 2'd2,
        SEL_NONE   = 2'd3
    } sel_t;

endpackage

// File: rtl/osc_ram.sv
module osc_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Registered read returns the old word on a same-edge write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/osc_sine_rom.sv
module osc_sine_rom #(
    parameter int IW = 8,
    parameter int OW = 8
) (
    input  logic                 clk,
    input  logic [IW-1:0]        idx,
    output logic signed [OW-1:0] amp
);

    localparam int  ENTRIES = 2 ** IW;
    localparam real PEAK    = real'((2 ** (OW - 1)) - 1);
    localparam real TWO_PI  = 6.283185307179586;

    function automatic logic signed [OW-1:0] sine_at(input int k);
        real x;
        x = PEAK * $sin(TWO_PI * real'(k) / real'(ENTRIES));
        if (x >= 0.0) begin
            return OW'($rtoi(x + 0.5));
        end
        return OW'($rtoi(x - 0.5));
    endfunction

    logic signed [OW-1:0] table_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_tbl
        assign table_q[i] = sine_at(i);
    end

    always_ff @(posedge clk) begin
        amp <= table_q[idx];
    end

endmodule

// File: rtl/osc_seq.sv
module osc_seq import oscb_pkg::*; #(
    parameter int NCH          = 1024,
    parameter int FRAME_PERIOD = 1088,
    parameter int CHW          = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_done,
    output state_t         state,
    output logic [CHW-1:0] ch,
    output logic           init_we,
    output logic           lead_vld,
    output logic           lead_last
);

    localparam int             TW        = $clog2(FRAME_PERIOD);
    localparam logic [CHW-1:0] CH_LAST   = CHW'(NCH - 1);
    localparam logic [TW-1:0]  TICK_LAST = TW'(FRAME_PERIOD - 1);

    state_t         state_q, state_d;
    logic [CHW-1:0] ch_q;
    logic [TW-1:0]  tick_q;
    logic           tick;

    // Sample-period counter, held at zero until the sweep ends.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_INIT) begin
            tick_q <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign tick = (state_q != ST_INIT) && (tick_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  if (ch_q == CH_LAST) state_d = ST_IDLE;   // init_done
            ST_IDLE:  if (tick)            state_d = ST_RUN;    // frame_go
            ST_RUN:   if (ch_q == CH_LAST) state_d = ST_DRAIN;  // last_issued
            ST_DRAIN: if (frame_done)      state_d = ST_IDLE;   // last_summed
            default:                       state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Shared channel counter: clears entries in INIT, issues channels in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            unique case (state_q)
                ST_INIT, ST_RUN: ch_q <= (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
                default:         ch_q <= '0;
            endcase
        end
    end

    always_comb begin
        state     = state_q;
        ch        = ch_q;
        init_we   = (state_q == ST_INIT);
        lead_vld  = (state_q == ST_RUN);
        lead_last = (state_q == ST_RUN) && (ch_q == CH_LAST);
    end

endmodule

// File: rtl/osc_bank.sv
module osc_bank import oscb_pkg::*; #(
    parameter int NCH          = 1024,
    parameter int PHW          = 32,
    parameter int SINW         = 8,
    parameter int AMPW         = 8,
    parameter int GW           = 16,
    parameter int OUTW         = 16,
    parameter int LAT          = 7,
    parameter int FRAME_PERIOD = 1088,
    parameter int OUT_SHIFT    = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [$clog2(NCH)-1:0]   host_ch,
    input  logic [1:0]               host_sel,
    input  logic [PHW-1:0]           host_data,
    output logic                     smp_valid,
    output logic [OUTW-1:0]          smp_left,
    output logic [OUTW-1:0]          smp_right
);

    localparam int CHW  = $clog2(NCH);
    localparam int ACCW = AMPW + GW + CHW;
    localparam logic [CHW-1:0]         CH_LAST = CHW'(NCH - 1);
    localparam logic signed [ACCW-1:0] OUT_MAX = ACCW'((64'sd1 <<< (OUTW - 1)) - 64'sd1);
    localparam logic signed [ACCW-1:0] OUT_MIN = -OUT_MAX - ACCW'(1);

    state_t         state_q;
    logic [CHW-1:0] seq_ch;
    logic           init_we, lead_vld, lead_last, frame_done;
    logic           host_ok;

    osc_seq #(.NCH(NCH), .FRAME_PERIOD(FRAME_PERIOD), .CHW(CHW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .state     (state_q),
        .ch        (seq_ch),
        .init_we   (init_we),
        .lead_vld  (lead_vld),
        .lead_last (lead_last)
    );

    assign host_ok = host_we && !init_we;

    // Stage tracking: bit k is the lead issue from k+1 cycles back.
    logic [LAT:0]   vld_sr, last_sr;
    logic [CHW-1:0] ch_d1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr  <= '0;
            last_sr <= '0;
            ch_d1   <= '0;
        end else begin
            vld_sr  <= {vld_sr[LAT-1:0], lead_vld};
            last_sr <= {last_sr[LAT-1:0], lead_last};
            ch_d1   <= seq_ch;
        end
    end

    // Phase advance and write-back.
    logic [PHW-1:0] ph_rd, step_rd, ph_new;
    assign ph_new = ph_rd + step_rd;

    osc_ram #(.W(PHW), .DEPTH(NCH), .AW(CHW)) u_phase (
        .clk  (clk),
        .we   (init_we || vld_sr[0]),
        .waddr(init_we ? seq_ch : ch_d1),
        .wdata(init_we ? '0 : ph_new),
        .raddr(seq_ch),
        .rdata(ph_rd)
    );

    osc_ram #(.W(PHW), .DEPTH(NCH), .AW(CHW)) u_step (
        .clk  (clk),
        .we   (init_we || (host_ok && sel_t'(host_sel) == SEL_STEP)),
        .waddr(init_we ? seq_ch : host_ch),
        .wdata(init_we ? '0 : host_data),
        .raddr(seq_ch),
        .rdata(step_rd)
    );

    // Table lookup from the updated phase.
    logic [SINW-1:0]        idx_q;
    logic signed [AMPW-1:0] amp_rom, amp_al;

    always_ff @(posedge clk) begin
        idx_q <= ph_new[PHW-1 -: SINW];
    end

    osc_sine_rom #(.IW(SINW), .OW(AMPW)) u_rom (
        .clk(clk),
        .idx(idx_q),
        .amp(amp_rom)
    );

    // Amplitude delay: table output is at stage 3, gains arrive at LAT+1.
    logic signed [AMPW-1:0] amp_dl [LAT-2];
    always_ff @(posedge clk) begin
        amp_dl[0] <= amp_rom;
        for (int j = 1; j < LAT - 2; j++) begin
            amp_dl[j] <= amp_dl[j-1];
        end
    end
    assign amp_al = amp_dl[LAT-3];

    // Trailing channel counter, LAT cycles behind the lead.
    logic           trail_en;
    logic [CHW-1:0] trail_q;
    assign trail_en = vld_sr[LAT-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trail_q <= '0;
        end else if (trail_en) begin
            trail_q <= (trail_q == CH_LAST) ? '0 : trail_q + 1'b1;
        end
    end

    logic acc_en, acc_last;
    assign acc_en     = vld_sr[LAT];
    assign acc_last   = last_sr[LAT];
    assign frame_done = acc_last;

    function automatic logic [OUTW-1:0] clamp_out(input logic signed [ACCW-1:0] v);
        logic signed [ACCW-1:0] sh;
        sh = v >>> OUT_SHIFT;
        if (sh > OUT_MAX) return {1'b0, {(OUTW-1){1'b1}}};
        if (sh < OUT_MIN) return {1'b1, {(OUTW-1){1'b0}}};
        return sh[OUTW-1:0];
    endfunction

    // One gain RAM, multiplier, accumulator and sample register per side.
    logic [GW-1:0]          gain_rd [2];
    logic signed [ACCW-1:0] acc_q   [2];
    logic [OUTW-1:0]        out_q   [2];

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic signed [ACCW-1:0] prod, sum;

        osc_ram #(.W(GW), .DEPTH(NCH), .AW(CHW)) u_gain (
            .clk  (clk),
            .we   (init_we || (host_ok && host_sel == 2'(s + 1))),
            .waddr(init_we ? seq_ch : host_ch),
            .wdata(init_we ? '0 : host_data[GW-1:0]),
            .raddr(trail_q),
            .rdata(gain_rd[s])
        );

        assign prod = ACCW'(amp_al) * ACCW'($signed(gain_rd[s]));
        assign sum  = acc_q[s] + prod;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[s] <= '0;
                out_q[s] <= '0;
            end else if (acc_en) begin
                if (acc_last) begin
                    acc_q[s] <= '0;
                    out_q[s] <= clamp_out(sum);
                end else begin
                    acc_q[s] <= sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= acc_en && acc_last;
        end
    end

    assign smp_left  = out_q[0];
    assign smp_right = out_q[1];

endmodule

// File: rtl/osc_bank_chk.sv
module osc_bank_chk import oscb_pkg::*; #(
    parameter int NCH  = 1024,
    parameter int LAT  = 7,
    parameter int ACCW = 34,
    parameter int CHW  = $clog2(NCH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input state_t                 state,
    input logic                   lead_vld,
    input logic [CHW-1:0]         lead_ch,
    input logic                   trail_en,
    input logic [CHW-1:0]         trail_ch,
    input logic signed [ACCW-1:0] acc_l,
    input logic signed [ACCW-1:0] acc_r,
    input logic                   out_valid
);

    // Own record of lead issues; LAT is small, so the line stays short.
    logic           dly_vld [LAT];
    logic [CHW-1:0] dly_ch  [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                dly_vld[i] <= 1'b0;
                dly_ch[i]  <= '0;
            end
        end else begin
            dly_vld[0] <= lead_vld;
            dly_ch[0]  <= lead_ch;
            for (int i = 1; i < LAT; i++) begin
                dly_vld[i] <= dly_vld[i-1];
                dly_ch[i]  <= dly_ch[i-1];
            end
        end
    end

    assert_trail_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trail_en |-> (dly_vld[LAT-1] && trail_ch == dly_ch[LAT-1]));

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_strobe_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state) == ST_DRAIN);

    assert_acc_clear_at_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_l == '0 && acc_r == '0));

    assert_acc_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (acc_l == '0 && acc_r == '0));

    assert_no_issue_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |-> !lead_vld);

endmodule

bind osc_bank osc_bank_chk #(.NCH(NCH), .LAT(LAT), .ACCW(ACCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .lead_vld (lead_vld),
    .lead_ch  (seq_ch),
    .trail_en (trail_en),
    .trail_ch (trail_q),
    .acc_l    (acc_q[0]),
    .acc_r    (acc_q[1]),
    .out_valid(smp_valid)
);

// File: tb/tb_osc_bank.sv
module tb_osc_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int LAT        = 7;
    localparam int FP         = 64;
    localparam int SHIFT      = 6;
    localparam int CHW        = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           host_we;
    logic [CHW-1:0] host_ch;
    logic [1:0]     host_sel;
    logic [31:0]    host_data;
    logic           smp_valid;
    logic [15:0]    smp_left, smp_right;

    osc_bank #(
        .NCH(NCH), .LAT(LAT), .FRAME_PERIOD(FP), .OUT_SHIFT(SHIFT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_ch(host_ch),
        .host_sel(host_sel), .host_data(host_data), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int     errors = 0;
    int     checks = 0;
    bit     done   = 0;
    longint cyc    = 0;
    longint last_strobe = -1;
    longint rel_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] m_ph  [NCH];
    logic [31:0] m_inc [NCH];
    int          m_gl  [NCH];
    int          m_gr  [NCH];

    function automatic int sine_ref(input int k);
        real x;
        x = 127.0 * $sin(6.283185307179586 * real'(k) / 256.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : $rtoi(x - 0.5);
    endfunction

    function automatic int clamp16(input longint v);
        longint sh;
        sh = v >>> SHIFT;
        if (sh > 32767) return 32767;
        if (sh < -32768) return -32768;
        return int'(sh);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int ch, input int sel, input logic [31:0] d, input bit upd);
        host_we   = 1'b1;
        host_ch   = CHW'(ch);
        host_sel  = 2'(sel);
        host_data = d;
        @(negedge clk);
        host_we   = 1'b0;
        if (upd) begin
            case (sel)
                0: m_inc[ch] = d;
                1: m_gl[ch]  = int'($signed(d[15:0]));
                2: m_gr[ch]  = int'($signed(d[15:0]));
                default: ;
            endcase
        end
    endtask

    task automatic run_frame(input string req);
        longint sl = 0, sr = 0;
        int     a;
        for (int ch = 0; ch < NCH; ch++) begin
            m_ph[ch] = m_ph[ch] + m_inc[ch];
            a  = sine_ref(int'(m_ph[ch][31:24]));
            sl += longint'(a) * longint'(m_gl[ch]);
            sr += longint'(a) * longint'(m_gr[ch]);
        end
        do @(negedge clk); while (!smp_valid);
        check({req, " left"},  longint'($signed(smp_left)),  longint'(clamp16(sl)));
        check({req, " right"}, longint'($signed(smp_right)), longint'(clamp16(sr)));
        if (last_strobe >= 0) begin
            check("R2 strobe spacing", cyc - last_strobe, FP);
        end else begin
            check("R10 first strobe time", cyc - rel_cyc, 2 * NCH + LAT + 2);
        end
        last_strobe = cyc;
        @(negedge clk);
        check("R2 strobe width", longint'(smp_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            m_ph[ch] = '0; m_inc[ch] = '0; m_gl[ch] = 0; m_gr[ch] = 0;
        end
        rst_n = 1'b0; host_we = 1'b0; host_ch = '0; host_sel = '0; host_data = '0;
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        check("R1 reset valid", longint'(smp_valid), 0);
        check("R1 reset left",  longint'(smp_left), 0);
        check("R1 reset right", longint'(smp_right), 0);
        rst_n   = 1'b1;
        rel_cyc = cyc;
        // R1: writes during the INIT sweep must be dropped
        host_write(3, 0, 32'h0100_0000, 0);
        host_write(5, 0, 32'h2200_0000, 0);
        host_write(2, 1, 32'h0000_1234, 0);

        run_frame("R1 R10 first frame");

        for (int ch = 0; ch < NCH; ch++) begin
            host_write(ch, 1, 32'(1000 + 10 * ch), 1);
            host_write(ch, 2, 32'(-500), 1);
        end
        // R9: select code 3 must not touch any entry
        host_write(0, 3, 32'h4000_0000, 0);
        run_frame("R1 R9 init-drop and no-effect select");

        for (int ch = 0; ch < NCH; ch++) begin
            host_write(ch, 0, 32'((ch + 1) * 32'h0130_0000 + ch * 777), 1);
        end
        host_write(6, 3, 32'h0000_7fff, 0);
        for (int f = 0; f < 3; f++) run_frame("R3 R4 R5 R7 R8 R9 sum");

        for (int ch = 0; ch < NCH; ch++) begin
            host_write(ch, 1, 32'h0000_7fff, 1);
            host_write(ch, 2, 32'h0000_8000, 1);
        end
        for (int f = 0; f < 3; f++) run_frame("R6 full-scale clamp");

        for (int ch = 0; ch < NCH; ch++) begin
            host_write(ch, 1, 32'(ch * 1500 - 4000), 1);
            host_write(ch, 2, 32'(20000 - ch * 3000), 1);
        end
        for (int ch = 0; ch < NCH; ch += 2) begin
            host_write(ch, 0, 32'hfe80_0000 - 32'(ch * 4099), 1);
        end
        for (int f = 0; f < 4; f++) run_frame("R3 R4 R5 R6 R7 mixed gains");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule